// File: doc/BRIEF.md
# Indexed Endpoint FIFO Bank for a Low-Speed USB Device

This block holds the buffering and per-endpoint state that sits behind a low-speed USB device engine with four endpoints. Endpoint 0 is the control endpoint and endpoints 1 to 3 carry data. A processor reaches every endpoint through one small register window. An index register chooses which endpoint's control, count, data and status registers appear at the shared addresses.

The packet side is a simplified byte interface. It names an endpoint and can push bytes received in an OUT data stage, pop bytes for an IN data stage, and report an ACK handshake in either direction. In return it sees, for the named endpoint, the data-toggle bits, the stall controls, the armed transmit length and a NAK indication. An ACK on an endpoint raises that endpoint's completion flag. The flags, masked by their enables, drive one interrupt line.

Each FIFO holds 8 bytes, which is the low-speed maximum packet size. Each FIFO also has a flush control that clears itself one cycle after it is written.

Top module: `usbep_bank`

## Requirements
- R1: After reset, INDEX and FADDR read 0, every receive count is 0, every flag and enable is 0, irq is 0, both toggle bits are 0 and pk_nak is 1 for every endpoint.
- R2: INDEX (address 0, bits 1:0) selects the endpoint whose registers are seen at addresses 2 to 10. Register contents of the other endpoints are unaffected and not visible.
- R3: FADDR (address 1) stores a 7-bit device address in bits 6:0. Bit 7 always reads 0.
- R4: Bytes pushed by the packet side for endpoint pk_ep are kept in order. RXCNT (address 3, bits 3:0) shows how many are held. A read of RXDAT (address 4) returns the oldest byte and removes it. cpu_rdata is valid in the cycle after the read strobe.
- R5: The receive count saturates at 8. A push into a full receive FIFO is dropped and sets the overrun bit, RXST bit 0 (address 6).
- R6: Writing 1 to RXCTL bit 7 (address 5) empties the selected receive FIFO on the next clock and clears its count, its overrun bit and its receive toggle. The bit reads 0 once that flush has happened.
- R7: Writes to TXDAT (address 8) fill the selected transmit FIFO. pk_tx_byte shows the oldest byte for pk_ep, or 0 when that FIFO is empty, and pk_tx_pop removes it. Writing 1 to TXCTL bit 7 (address 9) flushes the FIFO and clears the armed state and the transmit toggle.
- R8: A write to TXCNT (address 7) arms the endpoint with a length in bits 3:0, which is shown on pk_tx_len. pk_nak is 1 while the endpoint is not armed. A transmit ACK disarms the endpoint. TXST bit 0 (address 10) reads the armed state.
- R9: The receive toggle (RXST bit 7) flips on pk_rx_ack and the transmit toggle (TXST bit 7) flips on pk_tx_ack, each for endpoint pk_ep. The toggles are shown on pk_rx_seq and pk_tx_seq. A processor write to bit 7 of RXST or TXST sets the toggle directly.
- R10: EPCTL (address 2) bit 7 stalls reception and bit 6 stalls transmission. These appear on pk_rx_stall and pk_tx_stall for pk_ep.
- R11: IFLAG (address 11) bit i is set by any ACK on endpoint i and is cleared by writing 1 to it. When a set and a clear fall in the same cycle, the set wins. IEN (address 12) bit i enables flag i. irq is 1 when any enabled flag is set.
- R12: A packet-side push and a processor RXDAT read on the same endpoint in the same cycle both take effect. The count is unchanged and byte order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| pk_ep | input | 2 | Endpoint addressed by the packet side |
| pk_rx_push | input | 1 | Push a received byte |
| pk_rx_byte | input | 8 | Received byte |
| pk_rx_ack | input | 1 | ACK completed for an OUT transaction |
| pk_tx_pop | input | 1 | Pop a byte to send |
| pk_tx_byte | output | 8 | Oldest transmit byte of pk_ep |
| pk_tx_ack | input | 1 | Valid ACK received for an IN packet |
| pk_tx_len | output | 4 | Armed transmit length of pk_ep |
| pk_nak | output | 1 | pk_ep has no armed IN data |
| pk_rx_seq | output | 1 | Receive toggle of pk_ep |
| pk_tx_seq | output | 1 | Transmit toggle of pk_ep |
| pk_rx_stall | output | 1 | Receive stall of pk_ep |
| pk_tx_stall | output | 1 | Transmit stall of pk_ep |
| irq | output | 1 | Any enabled completion flag |

## Verification
Two things can hit one receive FIFO in the same cycle: a packet-side push and a processor read of RXDAT. The bench loads three known bytes into one endpoint. It then raises the RXDAT read strobe and a push of a fourth byte on the same clock edge. The result is judged by three checks: the read returns the first byte, RXCNT still reads 3, and the later reads return the remaining bytes followed by the pushed one.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
  typedef enum logic [3:0] {
    A_INDEX = 4'd0,
    A_FADDR = 4'd1,
    A_EPCTL = 4'd2,
    A_RXCNT = 4'd3,
    A_RXDAT = 4'd4,
    A_RXCTL = 4'd5,
    A_RXST  = 4'd6,
    A_TXCNT = 4'd7,
    A_TXDAT = 4'd8,
    A_TXCTL = 4'd9,
    A_TXST  = 4'd10,
    A_IFLAG = 4'd11,
    A_IEN   = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/usbep_fifo.sv
module usbep_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign do_push = push && (count < CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = (count != '0) ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && !do_push) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/usbep_epctl.sv
module usbep_epctl #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic [1:0]    stall_in,
  input  logic          wr_rxst,
  input  logic          wr_txst,
  input  logic          seq_in,
  input  logic          wr_txcnt,
  input  logic [LW-1:0] len_in,
  input  logic          rx_flush,
  input  logic          tx_flush,
  input  logic          rx_ack,
  input  logic          tx_ack,
  input  logic          flag_clr,
  output logic          rx_stall,
  output logic          tx_stall,
  output logic          rx_seq,
  output logic          tx_seq,
  output logic          armed,
  output logic [LW-1:0] tx_len,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_stall <= 1'b0;
      tx_stall <= 1'b0;
      rx_seq   <= 1'b0;
      tx_seq   <= 1'b0;
      armed    <= 1'b0;
      tx_len   <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_ctl) {rx_stall, tx_stall} <= stall_in;

      if (rx_flush)     rx_seq <= 1'b0;
      else if (wr_rxst) rx_seq <= seq_in;
      else if (rx_ack)  rx_seq <= ~rx_seq;

      if (tx_flush)     tx_seq <= 1'b0;
      else if (wr_txst) tx_seq <= seq_in;
      else if (tx_ack)  tx_seq <= ~tx_seq;

      if (tx_flush) begin
        armed  <= 1'b0;
        tx_len <= '0;
      end else if (wr_txcnt) begin
        armed  <= 1'b1;
        tx_len <= len_in;
      end else if (tx_ack) begin
        armed  <= 1'b0;
      end

      if (rx_ack || tx_ack) flag <= 1'b1;
      else if (flag_clr)    flag <= 1'b0;
    end
  end
endmodule

// File: rtl/usbep_bank.sv
module usbep_bank
  import usbep_pkg::*;
#(
  parameter int NEP   = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int EPW  = $clog2(NEP),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_we,
  input  logic           cpu_re,
  input  logic [3:0]     cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [EPW-1:0] pk_ep,
  input  logic           pk_rx_push,
  input  logic [DW-1:0]  pk_rx_byte,
  input  logic           pk_rx_ack,
  input  logic           pk_tx_pop,
  output logic [DW-1:0]  pk_tx_byte,
  input  logic           pk_tx_ack,
  output logic [CW-1:0]  pk_tx_len,
  output logic           pk_nak,
  output logic           pk_rx_seq,
  output logic           pk_tx_seq,
  output logic           pk_rx_stall,
  output logic           pk_tx_stall,
  output logic           irq
);
  logic [EPW-1:0]           idx;
  logic [6:0]               faddr;
  logic [NEP-1:0]           ien;
  logic [NEP-1:0]           rx_clr_q, tx_clr_q;
  logic [NEP-1:0][CW-1:0]   rx_cnt, tx_cnt, tx_len;
  logic [NEP-1:0][DW-1:0]   rx_dout, tx_dout;
  logic [NEP-1:0]           rx_ovf, rx_seq, tx_seq, rx_stall, tx_stall;
  logic [NEP-1:0]           armed, flag;

  logic wr_any, rd_rxdat;
  assign wr_any   = cpu_we;
  assign rd_rxdat = cpu_re && (cpu_addr == A_RXDAT);

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    logic sel, pk_sel;
    assign sel    = (idx == EPW'(i));
    assign pk_sel = (pk_ep == EPW'(i));

    usbep_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst(rst), .flush(rx_clr_q[i]),
      .push(pk_rx_push && pk_sel), .din(pk_rx_byte),
      .pop(rd_rxdat && sel), .dout(rx_dout[i]),
      .count(rx_cnt[i]), .ovf(rx_ovf[i])
    );

    logic tx_ovf_unused;
    usbep_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst(rst), .flush(tx_clr_q[i]),
      .push(wr_any && sel && (cpu_addr == A_TXDAT)), .din(cpu_wdata),
      .pop(pk_tx_pop && pk_sel), .dout(tx_dout[i]),
      .count(tx_cnt[i]), .ovf(tx_ovf_unused)
    );

    usbep_epctl #(.LW(CW)) u_ctl (
      .clk(clk), .rst(rst),
      .wr_ctl(wr_any && sel && (cpu_addr == A_EPCTL)),
      .stall_in(cpu_wdata[7:6]),
      .wr_rxst(wr_any && sel && (cpu_addr == A_RXST)),
      .wr_txst(wr_any && sel && (cpu_addr == A_TXST)),
      .seq_in(cpu_wdata[7]),
      .wr_txcnt(wr_any && sel && (cpu_addr == A_TXCNT)),
      .len_in(cpu_wdata[CW-1:0]),
      .rx_flush(rx_clr_q[i]), .tx_flush(tx_clr_q[i]),
      .rx_ack(pk_rx_ack && pk_sel), .tx_ack(pk_tx_ack && pk_sel),
      .flag_clr(wr_any && (cpu_addr == A_IFLAG) && cpu_wdata[i]),
      .rx_stall(rx_stall[i]), .tx_stall(tx_stall[i]),
      .rx_seq(rx_seq[i]), .tx_seq(tx_seq[i]),
      .armed(armed[i]), .tx_len(tx_len[i]), .flag(flag[i])
    );

    // Self-clearing flush bits: high for exactly one cycle after the write
    always_ff @(posedge clk) begin
      if (rst) begin
        rx_clr_q[i] <= 1'b0;
        tx_clr_q[i] <= 1'b0;
      end else begin
        rx_clr_q[i] <= wr_any && sel && (cpu_addr == A_RXCTL) && cpu_wdata[7];
        tx_clr_q[i] <= wr_any && sel && (cpu_addr == A_TXCTL) && cpu_wdata[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      faddr <= '0;
      ien   <= '0;
    end else if (wr_any) begin
      case (cpu_addr)
        A_INDEX: idx   <= cpu_wdata[EPW-1:0];
        A_FADDR: faddr <= cpu_wdata[6:0];
        A_IEN:   ien   <= cpu_wdata[NEP-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cpu_re) begin
      case (cpu_addr)
        A_INDEX: cpu_rdata <= DW'(idx);
        A_FADDR: cpu_rdata <= {1'b0, faddr};
        A_EPCTL: cpu_rdata <= {rx_stall[idx], tx_stall[idx], 6'b0};
        A_RXCNT: cpu_rdata <= DW'(rx_cnt[idx]);
        A_RXDAT: cpu_rdata <= rx_dout[idx];
        A_RXCTL: cpu_rdata <= {rx_clr_q[idx], 7'b0};
        A_RXST:  cpu_rdata <= {rx_seq[idx], 6'b0, rx_ovf[idx]};
        A_TXCTL: cpu_rdata <= {tx_clr_q[idx], 7'b0};
        A_TXST:  cpu_rdata <= {tx_seq[idx], 6'b0, armed[idx]};
        A_IFLAG: cpu_rdata <= DW'(flag);
        A_IEN:   cpu_rdata <= DW'(ien);
        default: cpu_rdata <= '0;
      endcase
    end
  end

  assign pk_tx_byte  = tx_dout[pk_ep];
  assign pk_tx_len   = tx_len[pk_ep];
  assign pk_nak      = ~armed[pk_ep];
  assign pk_rx_seq   = rx_seq[pk_ep];
  assign pk_tx_seq   = tx_seq[pk_ep];
  assign pk_rx_stall = rx_stall[pk_ep];
  assign pk_tx_stall = tx_stall[pk_ep];
  assign irq         = |(flag & ien);
endmodule

// File: rtl/usbep_bank_chk.sv
module usbep_bank_chk
  import usbep_pkg::*;
#(
  parameter int NEP   = 4,
  parameter int DEPTH = 8,
  localparam int EPW  = $clog2(NEP),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cpu_we,
  input logic [3:0]           cpu_addr,
  input logic [EPW-1:0]       idx,
  input logic [EPW-1:0]       pk_ep,
  input logic                 pk_rx_push,
  input logic                 pk_rx_ack,
  input logic                 pk_tx_ack,
  input logic [NEP-1:0]       rx_clr_q,
  input logic [NEP-1:0][CW-1:0] rx_cnt,
  input logic [NEP-1:0]       rx_ovf,
  input logic [NEP-1:0]       rx_seq,
  input logic [NEP-1:0]       armed,
  input logic [NEP-1:0]       flag
);
  for (genvar i = 0; i < NEP; i++) begin : g_chk
    // R9: receive toggle flips on an ACK when nothing else overrides it
    a_r9_rx_seq_toggle: assert property (@(posedge clk) disable iff (rst)
      (pk_rx_ack && pk_ep == EPW'(i) && !rx_clr_q[i] &&
       !(cpu_we && cpu_addr == A_RXST && idx == EPW'(i)))
      |=> (rx_seq[i] != $past(rx_seq[i])));

    // R8: a transmit ACK leaves the endpoint unarmed unless re-armed
    a_r8_ack_disarm: assert property (@(posedge clk) disable iff (rst)
      (pk_tx_ack && pk_ep == EPW'(i) &&
       !(cpu_we && cpu_addr == A_TXCNT && idx == EPW'(i)))
      |=> !armed[i]);

    // R11: any ACK on an endpoint raises its flag
    a_r11_flag_set: assert property (@(posedge clk) disable iff (rst)
      ((pk_rx_ack || pk_tx_ack) && pk_ep == EPW'(i)) |=> flag[i]);

    // R5: a push into a full receive FIFO marks overrun
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
      (pk_rx_push && pk_ep == EPW'(i) && rx_cnt[i] == CW'(DEPTH) && !rx_clr_q[i])
      |=> rx_ovf[i]);

    // R6: flush returns count, overrun and toggle to reset values
    a_r6_rx_flush: assert property (@(posedge clk) disable iff (rst)
      rx_clr_q[i] |=> (rx_cnt[i] == '0 && !rx_ovf[i] && !rx_seq[i]));
  end
endmodule

bind usbep_bank usbep_bank_chk #(.NEP(NEP), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .idx(idx),
  .pk_ep(pk_ep), .pk_rx_push(pk_rx_push), .pk_rx_ack(pk_rx_ack),
  .pk_tx_ack(pk_tx_ack), .rx_clr_q(rx_clr_q), .rx_cnt(rx_cnt),
  .rx_ovf(rx_ovf), .rx_seq(rx_seq), .armed(armed), .flag(flag)
);

// File: tb/tb_usbep_bank.sv
module tb_usbep_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 0, cpu_re = 0;
  logic [3:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic [1:0] pk_ep = 0;
  logic pk_rx_push = 0, pk_rx_ack = 0, pk_tx_pop = 0, pk_tx_ack = 0;
  logic [7:0] pk_rx_byte = 0;
  logic [7:0] pk_tx_byte;
  logic [3:0] pk_tx_len;
  logic pk_nak, pk_rx_seq, pk_tx_seq, pk_rx_stall, pk_tx_stall, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbep_bank dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cpu_re = 1; cpu_addr = a;
    @(negedge clk); cpu_re = 0; d = cpu_rdata;
  endtask

  task automatic push(input logic [1:0] ep, input logic [7:0] b);
    @(negedge clk); pk_ep = ep; pk_rx_push = 1; pk_rx_byte = b;
    @(negedge clk); pk_rx_push = 0;
  endtask

  task automatic pulse_ack(input logic [1:0] ep, input bit tx);
    @(negedge clk); pk_ep = ep; if (tx) pk_tx_ack = 1; else pk_rx_ack = 1;
    @(negedge clk); pk_tx_ack = 0; pk_rx_ack = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 index", d, 0);
    rd(3, d); chk("R1 rxcnt", d, 0);
    rd(11, d); chk("R1 flags", d, 0);
    pk_ep = 2; #1;
    chk("R1 nak", pk_nak, 1);
    chk("R1 irq", irq, 0);
    chk("R1 seq", {pk_rx_seq, pk_tx_seq}, 0);
  endtask

  task automatic t_faddr;
    logic [7:0] d;
    wr(1, 8'hFF); rd(1, d); chk("R3 faddr", d, 8'h7F);
  endtask

  task automatic t_rx_basic;
    logic [7:0] d;
    push(1, 8'h11); push(1, 8'h22); push(1, 8'h33);
    wr(0, 1); rd(3, d); chk("R4 count", d, 3);
    wr(0, 2); rd(3, d); chk("R2 other ep count", d, 0);
    wr(0, 1);
    rd(4, d); chk("R4 first", d, 8'h11);
    rd(4, d); chk("R4 second", d, 8'h22);
    rd(3, d); chk("R4 count after pops", d, 1);
  endtask

  task automatic t_overrun_flush;
    logic [7:0] d;
    for (int i = 0; i < 10; i++) push(3, 8'h40 + 8'(i));
    wr(0, 3);
    rd(3, d); chk("R5 saturated", d, 8);
    rd(6, d); chk("R5 overrun bit", d, 8'h01);
    rd(4, d); chk("R5 oldest kept", d, 8'h40);
    wr(5, 8'h80);
    @(negedge clk);
    rd(5, d); chk("R6 clear bit self-clears", d, 0);
    rd(3, d); chk("R6 count cleared", d, 0);
    rd(6, d); chk("R6 status cleared", d, 0);
  endtask

  task automatic t_seq;
    logic [7:0] d;
    wr(0, 1);
    pulse_ack(1, 0);
    rd(6, d); chk("R9 rx toggle set", d, 8'h80);
    pk_ep = 1; #1; chk("R9 pk_rx_seq", pk_rx_seq, 1);
    pulse_ack(1, 0);
    rd(6, d); chk("R9 rx toggle back", d, 0);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    wr(0, 2);
    wr(8, 8'hA1); wr(8, 8'hA2);
    pk_ep = 2; #1; chk("R8 nak unarmed", pk_nak, 1);
    wr(7, 8'h02);
    #1; chk("R8 armed", pk_nak, 0);
    chk("R8 length", pk_tx_len, 2);
    chk("R7 first byte", pk_tx_byte, 8'hA1);
    @(negedge clk); pk_tx_pop = 1;
    @(negedge clk); pk_tx_pop = 0;
    chk("R7 second byte", pk_tx_byte, 8'hA2);
    pulse_ack(2, 1);
    chk("R8 ack disarms", pk_nak, 1);
    chk("R9 tx toggle", pk_tx_seq, 1);
    rd(10, d); chk("R9 txst", d, 8'h80);
    wr(10, 8'h00); #1; chk("R9 cpu writes toggle", pk_tx_seq, 0);
    wr(8, 8'h55); wr(7, 8'h01); wr(10, 8'h80);
    wr(9, 8'h80);
    @(negedge clk);
    chk("R7 flushed byte", pk_tx_byte, 0);
    rd(10, d); chk("R7 flush clears status", d, 0);
  endtask

  task automatic t_stall;
    wr(0, 3); wr(2, 8'h80);
    pk_ep = 3; #1;
    chk("R10 rx stall", {pk_rx_stall, pk_tx_stall}, 2'b10);
    pk_ep = 0; #1;
    chk("R10 other ep", {pk_rx_stall, pk_tx_stall}, 2'b00);
    wr(2, 8'h40); pk_ep = 3; #1;
    chk("R10 tx stall", {pk_rx_stall, pk_tx_stall}, 2'b01);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    rd(11, d); chk("R11 flags", d, 8'h06);
    #1; chk("R11 masked", irq, 0);
    wr(12, 8'h02); #1; chk("R11 irq", irq, 1);
    wr(11, 8'h02); #1; chk("R11 cleared irq", irq, 0);
    rd(11, d); chk("R11 w1c", d, 8'h04);
    @(negedge clk); cpu_we = 1; cpu_addr = 11; cpu_wdata = 8'h08;
    pk_ep = 3; pk_rx_ack = 1;
    @(negedge clk); cpu_we = 0; pk_rx_ack = 0;
    rd(11, d); chk("R11 set wins", d, 8'h0C);
  endtask

  task automatic t_simul;
    logic [7:0] d;
    wr(0, 1); wr(5, 8'h80); @(negedge clk);
    push(1, 8'hB1); push(1, 8'hB2); push(1, 8'hB3);
    @(negedge clk);
    cpu_re = 1; cpu_addr = 4; pk_ep = 1; pk_rx_push = 1; pk_rx_byte = 8'hD4;
    @(negedge clk); cpu_re = 0; pk_rx_push = 0; d = cpu_rdata;
    chk("R12 read during push", d, 8'hB1);
    rd(3, d); chk("R12 count kept", d, 3);
    rd(4, d); chk("R12 order b2", d, 8'hB2);
    rd(4, d); chk("R12 order b3", d, 8'hB3);
    rd(4, d); chk("R12 order pushed", d, 8'hD4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_faddr();
    t_rx_basic();
    t_overrun_flush();
    t_seq();
    t_tx();
    t_stall();
    t_irq();
    t_simul();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule